// File: doc/BRIEF.md
# Four-Bit Command CRC Unit

This block computes the 4-bit check value that guards read responses and write commands on a short-range contactless memory card link. A single request carries a command bit, an address whose width follows the card's size class, and one data byte. The block captures these fields on a start pulse and shifts them serially through a 4-bit checksum register, one bit per clock. It then presents the checksum, a compare flag against a received checksum and a one-cycle completion pulse.

On the read path, the received 12-bit response is split by the caller. Bits 7:0 go to `data` and bits 11:8 go to `rx_crc`. The match flag then tells whether the response is intact. On the write path, the block also packs the full serial write-command word and reports its length. It refuses low addresses that hold the card identity and its checksum. Encryption of the bit stream and the radio layer are handled elsewhere.

Top module: `cmdcrc_unit`

## Requirements
- R1: While and after reset, before any start is accepted, `done` = 0, `wr_ok` = 0, `wr_word` = 0 and `crc_out` = 4'h5.
- R2: The checksum register starts from 4'h5. For each input bit b it takes f = crc[0] ^ b, shifts right by one, and XORs 4'hC when f = 1. No final XOR is applied.
- R3: The stream is fed one bit per clock in this order: the command bit (1 = read, 0 = write), then the address bits least significant first, then the 8 data bits least significant first.
- R4: `size_sel` selects the address width: 2'b00 gives 5 bits, 2'b01 gives 8 bits, and 2'b10 or 2'b11 gives 10 bits. Address bits above the selected width are ignored.
- R5: Suppose a start is accepted at clock edge E and N = address width + 9. Then `done` is high for exactly one cycle, after edge E+N. `crc_out` holds its result from then until the next accepted start.
- R6: When `done` is high, `match` is 1 exactly when `crc_out` equals the `rx_crc` captured at start. `match` is 0 while a computation runs.
- R7: A start pulse that arrives while a computation runs is ignored. The running result, its inputs and its single `done` pulse are unaffected.
- R8: For a write (cmd = 0) with masked address > 4, `wr_ok` = 1 once done. `wr_word` then holds the command bit 0 at bit 0, the address at bits aw:1, the data at bits aw+8:aw+1, the checksum at bits aw+12:aw+9 and zeros above. `wr_len` = aw + 13.
- R9: A write to a masked address of 4 or less is refused: `wr_ok` = 0 and `wr_word` = 0. A read likewise gives `wr_ok` = 0 and `wr_word` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture fields and begin a computation |
| cmd | input | 1 | Command bit: 1 read, 0 write |
| addr | input | 10 | Byte address (low bits used per size class) |
| size_sel | input | 2 | Card size class selecting address width |
| data | input | 8 | Data byte |
| rx_crc | input | 4 | Received checksum (response bits 11:8) |
| crc_out | output | 4 | Computed checksum |
| match | output | 1 | Computed checksum equals received one |
| done | output | 1 | One-cycle completion pulse |
| wr_ok | output | 1 | Write command word is valid and may be sent |
| wr_word | output | 23 | Packed write-command word |
| wr_len | output | 5 | Length of the write-command word in bits |

## Verification
Read requests are run with all three address widths and several data bytes, each against both a correct and a corrupted received checksum. This separates a wrong feed order or width choice from a faulty compare. Write requests at the refusal boundary (addresses 0, 4 and 5) and at wide addresses show whether the address limit and the field positions of the packed word are right. A small-class address with high bits set shows that masking happens before both the checksum and the refusal test. A second start pulse during a running computation shows that it neither restarts the computation nor adds a completion pulse.

// File: rtl/cmdcrc_pkg.sv
package cmdcrc_pkg;

   typedef enum logic [1:0] {
      SZ_SMALL = 2'b00,
      SZ_MID   = 2'b01,
      SZ_LARGE = 2'b10,
      SZ_ALT   = 2'b11
   } size_class_e;

   function automatic int unsigned class_width(input size_class_e c,
                                               input int unsigned ws,
                                               input int unsigned wm,
                                               input int unsigned wl);
      case (c)
         SZ_SMALL: return ws;
         SZ_MID:   return wm;
         default:  return wl;
      endcase
   endfunction

endpackage

// File: rtl/cmdcrc_core.sv
module cmdcrc_core #(
   parameter int               CRC_W     = 4,
   parameter logic [CRC_W-1:0] POLY      = 4'hC,
   parameter logic [CRC_W-1:0] SEED      = 4'h5,
   parameter bit               LSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             en,
   input  logic             din,
   output logic [CRC_W-1:0] crc
);
   logic [CRC_W-1:0] nxt;

   generate
      if (LSB_FIRST) begin : g_reflected
         always_comb begin
            nxt = crc >> 1;
            if (crc[0] ^ din) nxt = nxt ^ POLY;
         end
      end else begin : g_normal
         always_comb begin
            nxt = crc << 1;
            if (crc[CRC_W-1] ^ din) nxt = nxt ^ POLY;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    crc <= SEED;
      else if (load) crc <= SEED;
      else if (en)   crc <= nxt;
   end
endmodule

// File: rtl/cmdcrc_seq.sv
module cmdcrc_seq #(
   parameter int STREAM_W = 19,
   parameter int CNT_W    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [STREAM_W-1:0] stream_in,
   input  logic [CNT_W-1:0]    nbits,
   output logic                accept,
   output logic                bit_out,
   output logic                shift_en,
   output logic                busy,
   output logic                done
);
   logic [STREAM_W-1:0] sh;
   logic [CNT_W-1:0]    cnt;

   assign accept   = start && !busy;
   assign shift_en = busy;
   assign bit_out  = sh[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh   <= '0;
         cnt  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= busy && (cnt == CNT_W'(1));
         if (accept) begin
            sh   <= stream_in;
            cnt  <= nbits;
            busy <= (nbits != '0);
         end else if (busy) begin
            sh  <= sh >> 1;
            cnt <= cnt - CNT_W'(1);
            if (cnt == CNT_W'(1)) busy <= 1'b0;
         end
      end
   end

   a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r7_accept_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
endmodule

// File: rtl/cmdcrc_pack.sv
module cmdcrc_pack #(
   parameter int CRC_W      = 4,
   parameter int ADDR_W     = 10,
   parameter int DATA_W     = 8,
   parameter int AWW        = 4,
   parameter int WORD_W     = 23,
   parameter int REFUSE_MAX = 4
) (
   input  logic              valid,
   input  logic              cmd_bit,
   input  logic [ADDR_W-1:0] addr_m,
   input  logic [AWW-1:0]    aw,
   input  logic [DATA_W-1:0] data_b,
   input  logic [CRC_W-1:0]  crc,
   output logic              wr_ok,
   output logic [WORD_W-1:0] wr_word
);
   logic [WORD_W-1:0] raw;

   always_comb begin
      raw = (WORD_W'(crc) << (WORD_W'(aw) + WORD_W'(DATA_W + 1)))
          | (WORD_W'(data_b) << (WORD_W'(aw) + WORD_W'(1)))
          | (WORD_W'(addr_m) << 1)
          | WORD_W'(cmd_bit);
      wr_ok   = valid && !cmd_bit && (addr_m > ADDR_W'(REFUSE_MAX));
      wr_word = wr_ok ? raw : '0;
   end
endmodule

// File: rtl/cmdcrc_unit.sv
module cmdcrc_unit
   import cmdcrc_pkg::*;
#(
   parameter int               CRC_W      = 4,
   parameter logic [CRC_W-1:0] POLY       = 4'hC,
   parameter logic [CRC_W-1:0] SEED       = 4'h5,
   parameter bit               LSB_FIRST  = 1'b1,
   parameter int               DATA_W     = 8,
   parameter int               AW_S       = 5,
   parameter int               AW_M       = 8,
   parameter int               AW_L       = 10,
   parameter int               REFUSE_MAX = 4,
   localparam int ADDR_W   = AW_L,
   localparam int STREAM_W = 1 + AW_L + DATA_W,
   localparam int WORD_W   = STREAM_W + CRC_W,
   localparam int CNT_W    = $clog2(STREAM_W + 1),
   localparam int AWW      = $clog2(AW_L + 1),
   localparam int LEN_W    = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cmd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size_sel,
   input  logic [DATA_W-1:0] data,
   input  logic [CRC_W-1:0]  rx_crc,
   output logic [CRC_W-1:0]  crc_out,
   output logic              match,
   output logic              done,
   output logic              wr_ok,
   output logic [WORD_W-1:0] wr_word,
   output logic [LEN_W-1:0]  wr_len
);
   generate
      if (!(AW_S > 0 && AW_S <= AW_M && AW_M <= AW_L))
         $error("address widths must be ordered and non-zero");
      if (CRC_W < 2 || DATA_W < 1)
         $error("checksum or data width too small");
   endgenerate

   logic [AWW-1:0]      aw_in, aw_q;
   logic [ADDR_W-1:0]   addr_mask, addr_q;
   logic [STREAM_W-1:0] stream;
   logic [CNT_W-1:0]    nbits;
   logic                cmd_q, accept, bit_s, shift_en, busy;
   logic [DATA_W-1:0]   data_q;
   logic [CRC_W-1:0]    rx_q;

   always_comb begin
      aw_in     = AWW'(class_width(size_class_e'(size_sel), AW_S, AW_M, AW_L));
      addr_mask = ~({ADDR_W{1'b1}} << aw_in);
      stream    = (STREAM_W'(data) << (STREAM_W'(aw_in) + STREAM_W'(1)))
                | (STREAM_W'(addr & addr_mask) << 1)
                | STREAM_W'(cmd);
      nbits     = CNT_W'(aw_in) + CNT_W'(DATA_W + 1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= 1'b1;
         addr_q <= '0;
         data_q <= '0;
         rx_q   <= '0;
         aw_q   <= AWW'(AW_S);
      end else if (accept) begin
         cmd_q  <= cmd;
         addr_q <= addr & addr_mask;
         data_q <= data;
         rx_q   <= rx_crc;
         aw_q   <= aw_in;
      end
   end

   cmdcrc_seq #(.STREAM_W(STREAM_W), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .stream_in(stream), .nbits(nbits),
      .accept(accept), .bit_out(bit_s), .shift_en(shift_en), .busy(busy), .done(done)
   );

   cmdcrc_core #(.CRC_W(CRC_W), .POLY(POLY), .SEED(SEED), .LSB_FIRST(LSB_FIRST)) u_core (
      .clk(clk), .rst_n(rst_n), .load(accept), .en(shift_en), .din(bit_s), .crc(crc_out)
   );

   cmdcrc_pack #(.CRC_W(CRC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AWW(AWW),
                 .WORD_W(WORD_W), .REFUSE_MAX(REFUSE_MAX)) u_pack (
      .valid(!busy), .cmd_bit(cmd_q), .addr_m(addr_q), .aw(aw_q), .data_b(data_q),
      .crc(crc_out), .wr_ok(wr_ok), .wr_word(wr_word)
   );

   assign match  = !busy && (crc_out == rx_q);
   assign wr_len = LEN_W'(aw_q) + LEN_W'(DATA_W + CRC_W + 1);

   logic [WORD_W-1:0] top_field;
   assign top_field = wr_word >> (wr_len - LEN_W'(CRC_W));

   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(crc_out));
   a_r6_no_match_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !match);
   a_r8_word_crc_top: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |-> (top_field[CRC_W-1:0] == crc_out));
   a_r9_refused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !wr_ok) |-> (wr_word == '0));
endmodule

// File: tb/tb_cmdcrc_unit.sv
module tb_cmdcrc_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        cmd = 1'b1;
   logic [9:0]  addr = '0;
   logic [1:0]  size_sel = '0;
   logic [7:0]  data = '0;
   logic [3:0]  rx_crc = '0;
   logic [3:0]  crc_out;
   logic        match, done, wr_ok;
   logic [22:0] wr_word;
   logic [4:0]  wr_len;

   always #4 clk = ~clk;

   cmdcrc_unit dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr(addr),
      .size_sel(size_sel), .data(data), .rx_crc(rx_crc), .crc_out(crc_out),
      .match(match), .done(done), .wr_ok(wr_ok), .wr_word(wr_word), .wr_len(wr_len)
   );

   typedef struct {
      logic [3:0]  crc;
      logic        mt;
      logic        ok;
      logic [31:0] word;
      int          len;
      int          lat;
      int          c0;
   } exp_t;

   exp_t q[$];
   int   total = 0;
   int   bad = 0;
   int   cyc = 0;
   bit   chk_low = 0;
   bit   ended = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input longint act, input longint expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   function automatic logic [3:0] model_crc(input logic c, input int am, input int aw, input int d);
      logic [3:0] st = 4'h5;
      logic [31:0] s;
      s = 32'(c) | (32'(am) << 1) | (32'(d) << (aw + 1));
      for (int i = 0; i < aw + 9; i++) begin
         logic fb;
         fb = st[0] ^ s[i];
         st = st >> 1;
         if (fb) st = st ^ 4'hC;
      end
      return st;
   endfunction

   task automatic run_op(input logic c, input int a, input logic [1:0] sel, input int d,
                         input bit good_rx, input bit poke);
      exp_t e;
      int aw, am;
      aw = (sel == 2'b00) ? 5 : (sel == 2'b01) ? 8 : 10;
      am = a & ((1 << aw) - 1);
      e.crc  = model_crc(c, am, aw, d);
      e.mt   = good_rx;
      e.ok   = (c == 1'b0) && (am > 4);
      e.word = e.ok ? ((32'(e.crc) << (aw + 9)) | (32'(d) << (aw + 1)) | (32'(am) << 1)) : 32'd0;
      e.len  = aw + 13;
      e.lat  = aw + 9 + 1;
      @(negedge clk);
      start = 1'b1; cmd = c; addr = 10'(a); size_sel = sel; data = 8'(d);
      rx_crc = good_rx ? e.crc : (e.crc ^ 4'h3);
      e.c0 = cyc;
      q.push_back(e);
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         @(negedge clk);
         start = 1'b1; cmd = ~c; addr = ~10'(a); data = ~8'(d); size_sel = 2'b00; rx_crc = ~rx_crc;
         @(negedge clk);
         start = 1'b0;
      end
      wait (q.size() == 0);
      @(negedge clk);
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (chk_low) begin
            check(done == 1'b0, "R5 done lasts one cycle", done, 0);
            chk_low = 0;
         end
         if (done) begin
            if (q.size() == 0) begin
               check(1'b0, "R7 unexpected done pulse", 1, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(crc_out == e.crc, "R2 R3 R4 checksum", crc_out, e.crc);
               check(cyc - e.c0 == e.lat, "R5 done latency", cyc - e.c0, e.lat);
               check(match == e.mt, "R6 match flag", match, e.mt);
               check(wr_ok == e.ok, "R8 R9 write accept", wr_ok, e.ok);
               check({9'd0, wr_word} == e.word, "R8 R9 write word", wr_word, e.word);
               if (e.ok) check(int'(wr_len) == e.len, "R8 write length", wr_len, e.len);
            end
            chk_low = 1;
         end
      end
   end

   initial begin
      repeat (3000) @(posedge clk);
      check(1'b0, "watchdog expired", cyc, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(done == 1'b0, "R1 reset done", done, 0);
      check(crc_out == 4'h5, "R1 reset crc", crc_out, 5);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 1'b0, "R1 idle done", done, 0);
      check(wr_ok == 1'b0, "R1 idle wr_ok", wr_ok, 0);
      check(wr_word == '0, "R1 idle wr_word", wr_word, 0);
      check(crc_out == 4'h5, "R1 idle crc", crc_out, 5);
      // R2 R3 R6: reads on the small class, good and bad received checksum
      run_op(1'b1, 9, 2'b00, 8'hA5, 1'b1, 1'b0);
      run_op(1'b1, 9, 2'b00, 8'hA5, 1'b0, 1'b0);
      run_op(1'b1, 0, 2'b00, 8'h00, 1'b1, 1'b0);
      // R4: each size class, including the alternate large code
      run_op(1'b1, 8'hC3, 2'b01, 8'h5A, 1'b1, 1'b0);
      run_op(1'b1, 10'h2F1, 2'b10, 8'hFF, 1'b1, 1'b0);
      run_op(1'b1, 10'h2F1, 2'b11, 8'h01, 1'b0, 1'b0);
      // R4: high address bits ignored on the small class
      run_op(1'b1, 10'h3E9, 2'b00, 8'h3C, 1'b1, 1'b0);
      // R8: writes on mid and large classes
      run_op(1'b0, 8'h37, 2'b01, 8'h81, 1'b1, 1'b0);
      run_op(1'b0, 10'h3A5, 2'b10, 8'h6E, 1'b1, 1'b0);
      // R9: refusal boundary on writes, masked refusal
      run_op(1'b0, 4, 2'b00, 8'h11, 1'b1, 1'b0);
      run_op(1'b0, 0, 2'b01, 8'h22, 1'b1, 1'b0);
      run_op(1'b0, 5, 2'b00, 8'h33, 1'b1, 1'b0);
      run_op(1'b0, 10'h3E4, 2'b00, 8'h44, 1'b1, 1'b0);
      // R7: start pulse while busy is ignored
      run_op(1'b0, 10'h155, 2'b10, 8'hC7, 1'b1, 1'b1);
      run_op(1'b1, 8'h80, 2'b01, 8'h9D, 1'b0, 1'b1);
      repeat (30) @(negedge clk);
      check(q.size() == 0, "R7 no pending results", q.size(), 0);
      finish_run();
   end
endmodule